// File: doc/BRIEF.md
# EEPROM Write-and-Poll Sequencer

This block is the master side of a two-wire serial bus, built to store one byte into a small 16-location serial EEPROM and then find out, by acknowledge polling, when the memory's internal programming cycle has ended. A client raises `start` for one clock with a 4-bit word address and an 8-bit data value. The block then generates the whole bus sequence itself: Start, device-select byte, address byte, data byte, an acknowledge slot after each byte, and a closing Stop.

The closing Stop launches the memory's self-timed write. The sequencer does not wait a fixed delay. It polls straight away: it sends Start and the write-mode device-select byte. If the memory ignores that byte, the sequencer sends Stop and polls again. The first acknowledged poll is closed with a Stop, and then `done` pulses.

A NACK on any byte of the write itself ends the operation with an acknowledge error. A poll count that reaches a configurable cap ends it with a timeout error. Both bus lines are open-drain: the block only pulls a line low through an enable output, and it reads the data line back. The bit rate comes from a system-clock divider, set for at most 400 kHz.

Top module: `ee_write_poll`

## Requirements
- R1: After reset, both line enables are low (lines released), and `busy`, `done`, `errAck` and `errTimeout` are all 0.
- R2: Every device-select byte, for the write and for each poll, is 0xA0: the code 1010, three zero bits, then a 0 read/write bit.
- R3: The device-select byte is followed by an address byte whose upper four bits are 0 and whose lower four bits are the word address, then by the data byte. Every byte is sent MSB first. A ninth clock follows each byte, with SDA released and sampled as the acknowledge (low means ACK).
- R4: Inside a byte, SDA changes only while SCL is low. A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. Every transaction opens with a Start and closes with a Stop.
- R5: Polling begins right after the Stop that ends the write. Each poll is Start plus device-select. A poll that is not acknowledged is followed by a Stop and a new poll. With a memory that refuses N polls, N+1 polls are sent.
- R6: An acknowledged poll is closed by a Stop before `done` pulses, with no error flag set and both lines released.
- R7: A NACK on the device-select, address or data byte of the write sets `errAck`, sends a Stop and pulses `done`, with no polling.
- R8: If the MAX_POLLS-th poll is refused, `errTimeout` is set, a Stop is sent and `done` pulses. Exactly MAX_POLLS polls are sent.
- R9: A `start` pulse while the block is busy is ignored. No second operation runs, and the latched address and data are kept.
- R10: `busy` is 1 from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse, and `busy` is 0 while it is high.
- R11: Each SCL high phase inside a byte lasts exactly 2*QTR_CYCLES system clocks.
- R12: The error flags hold their value after `done` and are cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| wordAddr | input | ADDR_W | Word address to write |
| wrData | input | 8 | Byte to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| errAck | output | 1 | The write was refused by a NACK |
| errTimeout | output | 1 | The poll limit ran out |
| sclOe | output | 1 | 1 pulls the clock line low |
| sdaOe | output | 1 | 1 pulls the data line low |
| sdaIn | input | 1 | Sampled level of the data line |

## Verification
The bench builds the block with QTR_CYCLES=2 and MAX_POLLS=4, and keeps two synchronizer stages. The short quarter makes a full byte last only 72 clocks, so runs with several polls stay brief, and the SCL high-phase width can be measured exactly at four clocks. The low cap lets a memory model that stays busy for ten polls hit the timeout after exactly four device-select bytes. Another case, where the memory becomes ready exactly at the cap, checks the boundary between success and timeout.

// File: rtl/ewp_pkg.sv
`timescale 1ns/1ps
package ewp_pkg;

  // Bus-level operations executed by the datapath
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_BYTE  = 2'd2
  } busOp_t;

  // Source of the byte shifted out by an OP_BYTE
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } byteSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     go;
    busOp_t   op;
    byteSel_t sel;
  } ctrlStrb_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam logic [2:0] DEV_SUB  = 3'b000;

endpackage

// File: rtl/ewp_datapath.sv
`timescale 1ns/1ps
module ewp_datapath
  import ewp_pkg::*;
#(
  parameter int QTR_CYCLES  = 63,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              sdaIn,
  output logic              engBusy,
  output logic              opDone,
  output logic              ackSeen,
  output logic              sclOe,
  output logic              sdaOe
);

  localparam int DIV_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QTR_CYCLES - 1);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              active;
  busOp_t            curOp;
  logic [1:0]        quarter;
  logic [3:0]        bitIdx;
  logic [DIV_W-1:0]  divCnt;
  logic [7:0]        shifter;
  logic              ackQ;
  logic              doneQ;
  logic              sclHold;
  logic              sdaHold;
  logic              sclNow;
  logic              sdaNow;
  logic [7:0]        txByte;
  logic              tick;
  logic              sdaSeen;
  logic [SYNC_STAGES-1:0] syncChain;

  // Input synchronizer for the data line
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= sdaIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sdaIn};
      end
    end
  endgenerate
  assign sdaSeen = syncChain[SYNC_STAGES-1];

  // Byte selection
  always_comb begin
    case (strb.sel)
      SEL_CTRL: txByte = {DEV_CODE, DEV_SUB, 1'b0};
      SEL_ADDR: txByte = 8'(addrQ);
      default:  txByte = dataQ;
    endcase
  end

  assign tick = active && (divCnt == DIV_LAST);

  // Sequencing of quarters and bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      active  <= 1'b0;
      curOp   <= OP_STOP;
      quarter <= 2'd0;
      bitIdx  <= 4'd0;
      divCnt  <= '0;
      shifter <= 8'd0;
      ackQ    <= 1'b0;
      doneQ   <= 1'b0;
      sclHold <= 1'b0;
      sdaHold <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
      end
      if (!active) begin
        if (strb.go) begin
          active  <= 1'b1;
          curOp   <= strb.op;
          quarter <= 2'd0;
          bitIdx  <= 4'd0;
          divCnt  <= '0;
          shifter <= txByte;
        end
      end else begin
        sclHold <= sclNow;
        sdaHold <= sdaNow;
        if (tick) begin
          divCnt <= '0;
          if (curOp == OP_BYTE && quarter == 2'd2 && bitIdx == ACK_SLOT)
            ackQ <= !sdaSeen;
          if (quarter == 2'd3) begin
            quarter <= 2'd0;
            if (curOp != OP_BYTE || bitIdx == ACK_SLOT) begin
              active <= 1'b0;
              doneQ  <= 1'b1;
            end else begin
              bitIdx  <= bitIdx + 4'd1;
              shifter <= {shifter[6:0], 1'b0};
            end
          end else begin
            quarter <= quarter + 2'd1;
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // Line drive per operation and quarter (1 = pull low)
  always_comb begin
    sclNow = sclHold;
    sdaNow = sdaHold;
    if (active) begin
      case (curOp)
        OP_START: begin
          case (quarter)
            2'd0:    begin sclNow = sclHold; sdaNow = 1'b0; end
            2'd1:    begin sclNow = 1'b0;    sdaNow = 1'b0; end
            2'd2:    begin sclNow = 1'b0;    sdaNow = 1'b1; end
            default: begin sclNow = 1'b1;    sdaNow = 1'b1; end
          endcase
        end
        OP_STOP: begin
          case (quarter)
            2'd0:    begin sclNow = 1'b1; sdaNow = 1'b1; end
            2'd1:    begin sclNow = 1'b0; sdaNow = 1'b1; end
            default: begin sclNow = 1'b0; sdaNow = 1'b0; end
          endcase
        end
        default: begin
          sclNow = (quarter == 2'd0) || (quarter == 2'd3);
          sdaNow = (bitIdx == ACK_SLOT) ? 1'b0 : !shifter[7];
        end
      endcase
    end
  end

  assign sclOe   = sclNow;
  assign sdaOe   = sdaNow;
  assign engBusy = active;
  assign opDone  = doneQ;
  assign ackSeen = ackQ;

  // R4: data may not move while the clock is released inside a byte
  a_r4_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (active && curOp == OP_BYTE && !sclOe && $past(!sclOe) && $past(active))
      |-> $stable(sdaOe));

  // R9: the request latch is frozen while the bus engine runs
  a_r9_req_frozen: assert property (@(posedge clk) disable iff (!rstN)
    engBusy |=> ($stable(addrQ) && $stable(dataQ)));

  // R10: completion of an operation always ends engine activity
  a_r10_done_ends_op: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> !engBusy);

endmodule

// File: rtl/ewp_ctrl.sv
`timescale 1ns/1ps
module ewp_ctrl
  import ewp_pkg::*;
#(
  parameter int MAX_POLLS = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      engBusy,
  input  logic      opDone,
  input  logic      ackSeen,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      errAck,
  output logic      errTimeout
);

  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam logic [PCW-1:0] POLL_CAP = PCW'(MAX_POLLS);

  typedef enum logic [3:0] {
    S_IDLE, S_W_START, S_W_CTRL, S_W_ADDR, S_W_DATA, S_W_STOP,
    S_P_START, S_P_CTRL, S_P_RETRY, S_P_STOP, S_ABORT, S_FIN
  } seqState_t;

  seqState_t      state;
  seqState_t      nextState;
  logic           pending;
  logic [PCW-1:0] pollCnt;
  logic           opState;
  logic           writeByte;

  assign opState   = (state != S_IDLE) && (state != S_FIN);
  assign writeByte = (state == S_W_CTRL) || (state == S_W_ADDR) || (state == S_W_DATA);

  // Strobes to datapath
  always_comb begin
    strb.load = start && (state == S_IDLE);
    strb.go   = opState && !pending && !engBusy;
    strb.op   = OP_BYTE;
    strb.sel  = SEL_CTRL;
    case (state)
      S_W_START, S_P_START:                   strb.op  = OP_START;
      S_W_STOP, S_P_RETRY, S_P_STOP, S_ABORT: strb.op  = OP_STOP;
      S_W_ADDR:                               strb.sel = SEL_ADDR;
      S_W_DATA:                               strb.sel = SEL_DATA;
      default: ;
    endcase
  end

  // Successor once the current bus operation completes
  always_comb begin
    case (state)
      S_W_START: nextState = S_W_CTRL;
      S_W_CTRL:  nextState = ackSeen ? S_W_ADDR : S_ABORT;
      S_W_ADDR:  nextState = ackSeen ? S_W_DATA : S_ABORT;
      S_W_DATA:  nextState = ackSeen ? S_W_STOP : S_ABORT;
      S_W_STOP:  nextState = S_P_START;
      S_P_START: nextState = S_P_CTRL;
      S_P_CTRL:  nextState = ackSeen ? S_P_STOP :
                             ((pollCnt >= POLL_CAP) ? S_ABORT : S_P_RETRY);
      S_P_RETRY: nextState = S_P_START;
      S_P_STOP:  nextState = S_FIN;
      S_ABORT:   nextState = S_FIN;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pending    <= 1'b0;
      pollCnt    <= '0;
      errAck     <= 1'b0;
      errTimeout <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start) begin
        state      <= S_W_START;
        errAck     <= 1'b0;
        errTimeout <= 1'b0;
        pollCnt    <= '0;
      end
    end else if (state == S_FIN) begin
      state <= S_IDLE;
    end else begin
      if (strb.go) pending <= 1'b1;
      if (opDone) begin
        pending <= 1'b0;
        state   <= nextState;
        if (state == S_P_START) pollCnt <= pollCnt + PCW'(1);
        if (writeByte && !ackSeen) errAck <= 1'b1;
        if (state == S_P_CTRL && !ackSeen && pollCnt >= POLL_CAP) errTimeout <= 1'b1;
      end
    end
  end

  assign busy = opState;
  assign done = (state == S_FIN);

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: busy only drops together with the completion pulse
  a_r10_busy_drop_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: the poll counter never passes the cap
  a_r8_poll_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_CAP);

  // R7: the two error causes never appear together
  a_r7_single_cause: assert property (@(posedge clk) disable iff (!rstN)
    !(errAck && errTimeout));

  // R5: polling is only entered from a Stop of the write or of a refused poll
  a_r5_poll_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_P_START && $past(state) != S_P_START)
      |-> ($past(state) == S_W_STOP || $past(state) == S_P_RETRY));

endmodule

// File: rtl/ee_write_poll.sv
`timescale 1ns/1ps
module ee_write_poll
  import ewp_pkg::*;
#(
  parameter int QTR_CYCLES  = 63,
  parameter int ADDR_W      = 4,
  parameter int MAX_POLLS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [7:0]        wrData,
  output logic              busy,
  output logic              done,
  output logic              errAck,
  output logic              errTimeout,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              sdaIn
);

  ctrlStrb_t strb;
  logic      engBusy;
  logic      opDone;
  logic      ackSeen;

  ewp_ctrl #(
    .MAX_POLLS (MAX_POLLS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .engBusy    (engBusy),
    .opDone     (opDone),
    .ackSeen    (ackSeen),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .errAck     (errAck),
    .errTimeout (errTimeout)
  );

  ewp_datapath #(
    .QTR_CYCLES  (QTR_CYCLES),
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (wordAddr),
    .reqData (wrData),
    .sdaIn   (sdaIn),
    .engBusy (engBusy),
    .opDone  (opDone),
    .ackSeen (ackSeen),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe)
  );

endmodule

// File: tb/ee_write_poll_bench.sv
`timescale 1ns/1ps
module ee_write_poll_bench;

  localparam int QTR   = 2;
  localparam int MAXP  = 4;
  localparam int HIGHW = 2 * QTR * 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] wordAddr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic busy, done, errAck, errTimeout, sclOe, sdaOe;
  logic slvLow = 1'b0;
  wire  scl = ~sclOe;
  wire  sda = ~(sdaOe | slvLow);

  ee_write_poll #(.QTR_CYCLES(QTR), .ADDR_W(4), .MAX_POLLS(MAXP), .SYNC_STAGES(2)) u_ee_write_poll (
    .clk(clk), .rstN(rstN), .start(start), .wordAddr(wordAddr), .wrData(wrData),
    .busy(busy), .done(done), .errAck(errAck), .errTimeout(errTimeout),
    .sclOe(sclOe), .sdaOe(sdaOe), .sdaIn(sda));

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [16];
  bit inTxn = 0, sawRise = 0, present = 1, nackAddr = 0, nackData = 0, dataAcked = 0;
  int bitCnt = 0, byteIdx = 0, ctrlSeen = 0, ctrlBad = 0, writes = 0;
  int busyCnt = 0, busyKnob = 0, startCnt = 0, stopCnt = 0, sclBad = 0;
  logic [7:0] sr = 0, addrByte = 0, dataByte = 0;
  time riseT = 0;

  always @(negedge sda) if (scl === 1'b1) begin
    inTxn = 1; bitCnt = 0; byteIdx = 0; sawRise = 0; dataAcked = 0; startCnt++;
  end

  always @(posedge sda) if (scl === 1'b1 && inTxn) begin
    inTxn = 0; stopCnt++;
    if (dataAcked) begin
      mem[addrByte[3:0]] = dataByte; writes++; busyCnt = busyKnob; dataAcked = 0;
    end
  end

  always @(posedge scl) if (inTxn) begin
    riseT = $time; sawRise = 1;
    if (bitCnt < 8) sr = {sr[6:0], sda};
  end

  always @(negedge scl) if (inTxn && sawRise) begin
    bit ack;
    sawRise = 0;
    if ($time - riseT != HIGHW) sclBad++;
    if (bitCnt < 7) bitCnt++;
    else if (bitCnt == 7) begin
      bitCnt = 8;
      ack = 0;
      case (byteIdx)
        0: begin
          ctrlSeen++;
          if (sr != 8'hA0) ctrlBad++;
          if (present && sr[7:4] == 4'hA && !sr[0]) begin
            if (busyCnt > 0) busyCnt--; else ack = 1;
          end
        end
        1: begin addrByte = sr; ack = !nackAddr; end
        2: begin dataByte = sr; ack = !nackData; dataAcked = ack; end
        default: ack = 0;
      endcase
      slvLow = ack;
    end else begin
      slvLow = 0; bitCnt = 0; byteIdx++;
    end
  end

  task automatic setDevice(input int bk, input bit pres, input bit na, input bit nd);
    busyKnob = bk; busyCnt = 0; present = pres; nackAddr = na; nackData = nd;
    ctrlSeen = 0; ctrlBad = 0; writes = 0; startCnt = 0; stopCnt = 0;
  endtask

  // Issue one request; returns on the negedge where done is high
  task automatic runWrite(input logic [3:0] a, input logic [7:0] d, input string req);
    bit seen;
    @(negedge clk); wordAddr = a; wrData = d; start = 1;
    @(negedge clk); start = 0;
    check("R10", "busy after accept", busy, 1);
    seen = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    check(req, "done seen", seen, 1);
    check("R10", "busy low with done", busy, 0);
  endtask

  task automatic afterDone();
    @(negedge clk);
    check("R10", "done single cycle", done, 0);
    check("R10", "busy idle after done", busy, 0);
    check("R4", "SCL released at end", sclOe, 0);
    check("R4", "SDA released at end", sdaOe, 0);
    check("R4", "every Start closed by Stop", stopCnt, startCnt);
    check("R11", "SCL high widths", sclBad, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "sclOe in reset", sclOe, 0);
    check("R1", "sdaOe in reset", sdaOe, 0);
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "errAck in reset", errAck, 0);
    check("R1", "errTimeout in reset", errTimeout, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_write_poll(input logic [3:0] a, input logic [7:0] d, input int bk);
    setDevice(bk, 1, 0, 0);
    runWrite(a, d, "R6");
    check("R6", "no ack error", errAck, 0);
    check("R6", "no timeout", errTimeout, 0);
    check("R3", "stored byte", mem[a], d);
    check("R3", "address byte", addrByte, {4'b0, a});
    check("R2", "device-select bytes", ctrlBad, 0);
    check("R5", "polls sent", ctrlSeen - 1, bk + 1);
    check("R4", "transactions opened", startCnt, bk + 2);
    afterDone();
  endtask

  task automatic t_nack(input bit pres, input bit na, input bit nd, input string what);
    mem[3] = 8'h11;
    setDevice(0, pres, na, nd);
    runWrite(4'd3, 8'h77, "R7");
    check("R7", {what, " errAck"}, errAck, 1);
    check("R7", {what, " errTimeout"}, errTimeout, 0);
    check("R7", {what, " no polls"}, ctrlSeen, 1);
    check("R7", {what, " memory untouched"}, mem[3], 8'h11);
    afterDone();
    repeat (5) @(negedge clk);
    check("R12", {what, " errAck held"}, errAck, 1);
  endtask

  task automatic t_timeout();
    setDevice(10, 1, 0, 0);
    runWrite(4'd9, 8'h5A, "R8");
    check("R8", "errTimeout", errTimeout, 1);
    check("R8", "errAck", errAck, 0);
    check("R8", "polls at cap", ctrlSeen - 1, MAXP);
    afterDone();
    repeat (5) @(negedge clk);
    check("R12", "errTimeout held", errTimeout, 1);
  endtask

  task automatic t_cap_edge();
    // memory refuses MAXP-1 polls: the last allowed poll succeeds
    setDevice(MAXP - 1, 1, 0, 0);
    runWrite(4'd10, 8'hC3, "R8");
    check("R8", "no timeout at cap edge", errTimeout, 0);
    check("R12", "flags cleared by new request", errAck, 0);
    check("R8", "polls at cap edge", ctrlSeen - 1, MAXP);
    afterDone();
  endtask

  task automatic t_ignore_start();
    mem[8] = 8'h00;
    setDevice(1, 1, 0, 0);
    @(negedge clk); wordAddr = 4'd7; wrData = 8'h42; start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    wordAddr = 4'd8; wrData = 8'h99; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 40000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R9", "first request stored", mem[7], 8'h42);
    check("R9", "second request dropped", mem[8], 8'h00);
    check("R9", "single write", writes, 1);
    afterDone();
    repeat (20) @(negedge clk);
    check("R9", "no follow-on operation", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    t_reset();
    t_write_poll(4'd5, 8'h3C, 2);
    t_write_poll(4'd15, 8'hA5, 0);
    t_write_poll(4'd0, 8'hFF, 1);
    t_nack(1, 0, 1, "data NACK");
    t_write_poll(4'd1, 8'h80, 0);
    check("R12", "errAck cleared", errAck, 0);
    t_nack(1, 1, 0, "address NACK");
    t_nack(0, 0, 0, "device absent");
    t_timeout();
    t_cap_edge();
    t_ignore_start();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule